// File: doc/BRIEF.md
# Three-Level PWM Input Decoder

This block turns a three-level PWM pin into one clean drive command for a gate sequencer. Two comparators sit in front of it. One flag says the pin is above the upper threshold and the other says it is below the lower threshold. The block classifies each sample as high, low or mid. A mid level means the pin is floating, parked by its controller, or otherwise inside the shutdown band.

The output is one of three commands: HIGH, LOW or OFF. A mid level is not trusted straight away. It must persist for a hold-off period before the command drops to OFF. Leaving OFF needs a short run of valid samples. Each change into HIGH or LOW is latched for a minimum time, so glitches on the pin cannot produce runt pulses at the gates. All times are counted in clock cycles and set by parameters.

Top module: `tpwm_decode`

## Requirements
- R1: When the minimum-time latch has expired, a sample with only `lvl_above` set selects HIGH and a sample with only `lvl_below` set selects LOW, from the next clock edge. HIGH is encoded as `drv_hi`=1, `drv_lo`=0 and LOW as `drv_hi`=0, `drv_lo`=1.
- R2: A sample with both flags set is treated exactly like a sample with neither flag set, that is, as a mid (window) level.
- R3: While driving HIGH or LOW, the command becomes OFF (`drv_hi`=`drv_lo`=0) at the edge that takes the HOLDOFF_CYC-th consecutive mid sample. A shorter mid run leaves the command unchanged, and the count restarts from zero after any valid sample.
- R4: Once HIGH is entered, it is held for at least MIN_HI_CYC clock cycles, whatever the input does.
- R5: Once LOW is entered, it is held for at least MIN_LO_CYC clock cycles, whatever the input does.
- R6: From OFF, the command takes the level of the sample at the edge that takes the EXIT_CYC-th consecutive valid (high or low) sample. Any mid sample restarts this count.
- R7: `drv_hi` and `drv_lo` are never both 1.
- R8: Reset, asserted low and asynchronous, forces OFF.
- R9: If the hold-off completes while the minimum-time latch is still active, the command goes OFF at the first edge after the latch expires, provided the input is still mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_above | input | 1 | Comparator flag: pin above upper threshold |
| lvl_below | input | 1 | Comparator flag: pin below lower threshold |
| drv_hi | output | 1 | High-side gate command |
| drv_lo | output | 1 | Low-side gate command |

## Verification
The shutdown hold-off and the minimum-time latch can mature on the same edge. This happens when a mid level arrives right after a new HIGH or LOW is entered and the hold-off is shorter than the latch. The bench uses a small configuration where that is true, and sweeps every mid-run length against every prior and following level. A cycle-accurate model written from the requirements predicts the exact edge at which OFF appears. That edge is either the hold-off edge or the first edge after the latch expires, whichever is later.

// File: rtl/tpwm_decode.sv
module tpwm_decode #(
  parameter int HOLDOFF_CYC = 13,
  parameter int MIN_HI_CYC  = 7,
  parameter int MIN_LO_CYC  = 8,
  parameter int EXIT_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_above,
  input  logic lvl_below,
  output logic drv_hi,
  output logic drv_lo
);
  localparam int M1   = (HOLDOFF_CYC > MIN_HI_CYC) ? HOLDOFF_CYC : MIN_HI_CYC;
  localparam int M2   = (MIN_LO_CYC > EXIT_CYC) ? MIN_LO_CYC : EXIT_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW:0]   HOLD_W = (CW+1)'(HOLDOFF_CYC);
  localparam logic [CW:0]   EXIT_W = (CW+1)'(EXIT_CYC);
  localparam logic [CW-1:0] HI_LD  = CW'(MIN_HI_CYC - 1);
  localparam logic [CW-1:0] LO_LD  = CW'(MIN_LO_CYC - 1);

  logic          is_hi, is_lo, is_mid;
  logic [1:0]    cmd, cmd_n, lvl;
  logic [CW-1:0] win_cnt, ext_cnt, lock_cnt, lock_n;
  logic [CW:0]   win_inc, ext_inc;
  logic          win_done, ext_done, lock_free;

  assign is_hi  = lvl_above & ~lvl_below;
  assign is_lo  = lvl_below & ~lvl_above;
  assign is_mid = ~(is_hi | is_lo);
  assign lvl    = {is_hi, is_lo};

  assign win_inc   = {1'b0, win_cnt} + (CW+1)'(1);
  assign ext_inc   = {1'b0, ext_cnt} + (CW+1)'(1);
  assign win_done  = is_mid  && (win_inc >= HOLD_W);
  assign ext_done  = !is_mid && (ext_inc >= EXIT_W);
  assign lock_free = (lock_cnt == '0);

  always_comb begin
    cmd_n  = cmd;
    lock_n = lock_free ? '0 : lock_cnt - CW'(1);
    if (cmd == 2'b00) begin
      if (ext_done) begin
        cmd_n  = lvl;
        lock_n = is_hi ? HI_LD : LO_LD;
      end
    end else if (lock_free) begin
      if (win_done) begin
        cmd_n = 2'b00;
      end else if (!is_mid && lvl != cmd) begin
        cmd_n  = lvl;
        lock_n = is_hi ? HI_LD : LO_LD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= 2'b00;
      lock_cnt <= '0;
      win_cnt  <= '0;
      ext_cnt  <= '0;
    end else begin
      cmd      <= cmd_n;
      lock_cnt <= lock_n;
      win_cnt  <= !is_mid ? '0 : (win_done ? win_cnt : win_inc[CW-1:0]);
      ext_cnt  <= is_mid  ? '0 : (ext_done ? ext_cnt : ext_inc[CW-1:0]);
    end
  end

  assign drv_hi = cmd[1];
  assign drv_lo = cmd[0];
endmodule

// File: rtl/tpwm_decode_chk.sv
module tpwm_decode_chk #(
  parameter int HOLDOFF_CYC = 13,
  parameter int MIN_HI_CYC  = 7,
  parameter int MIN_LO_CYC  = 8,
  parameter int EXIT_CYC    = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lvl_above,
  input logic lvl_below,
  input logic drv_hi,
  input logic drv_lo
);
  logic [15:0] mid_run, val_run, held;
  logic [1:0]  prev;
  logic        mid;

  assign mid = (lvl_above == lvl_below);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_run <= '0;
      val_run <= '0;
      held    <= '0;
      prev    <= 2'b00;
    end else begin
      mid_run <= mid  ? ((mid_run == 16'hFFFF) ? mid_run : mid_run + 16'd1) : '0;
      val_run <= !mid ? ((val_run == 16'hFFFF) ? val_run : val_run + 16'd1) : '0;
      prev    <= {drv_hi, drv_lo};
      if ({drv_hi, drv_lo} != prev) held <= 16'd1;
      else if (held != 16'hFFFF)    held <= held + 16'd1;
    end
  end

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  assert_reset_off_R8: assert property (@(posedge clk)
    !rst_n |=> (!drv_hi && !drv_lo));

  assert_level_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!drv_hi) && drv_hi) |-> $past(lvl_above && !lvl_below));

  assert_level_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!drv_lo) && drv_lo) |-> $past(lvl_below && !lvl_above));

  assert_holdoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_hi || drv_lo) && !drv_hi && !drv_lo) |-> (mid_run >= 16'(HOLDOFF_CYC)));

  assert_min_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_hi) && !drv_hi) |-> (held >= 16'(MIN_HI_CYC)));

  assert_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_lo) && !drv_lo) |-> (held >= 16'(MIN_LO_CYC)));

  assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!drv_hi && !drv_lo) && (drv_hi || drv_lo)) |-> (val_run >= 16'(EXIT_CYC)));
endmodule

bind tpwm_decode tpwm_decode_chk #(
  .HOLDOFF_CYC(HOLDOFF_CYC),
  .MIN_HI_CYC (MIN_HI_CYC),
  .MIN_LO_CYC (MIN_LO_CYC),
  .EXIT_CYC   (EXIT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lvl_above(lvl_above),
  .lvl_below(lvl_below),
  .drv_hi   (drv_hi),
  .drv_lo   (drv_lo)
);

// File: tb/sim_tpwm_decode.sv
`timescale 1ns/1ps
module sim_tpwm_decode;
  localparam int HOLD = 3;
  localparam int MHI  = 4;
  localparam int MLO  = 5;
  localparam int EXT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_above = 1'b0;
  logic lvl_below = 1'b0;
  logic drv_hi, drv_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  tpwm_decode #(.HOLDOFF_CYC(HOLD), .MIN_HI_CYC(MHI), .MIN_LO_CYC(MLO), .EXIT_CYC(EXT)) u0 (
    .clk(clk), .rst_n(rst_n), .lvl_above(lvl_above), .lvl_below(lvl_below),
    .drv_hi(drv_hi), .drv_lo(drv_lo));

  // model command: 0 HIGH, 1 LOW, 2 OFF
  int m_cmd, m_mid, m_val, m_since;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd <= 2; m_mid <= 0; m_val <= 0; m_since <= 0; m_tag <= "R8";
    end else begin
      int c, nm, nv, need, nc;
      bit both, ok;
      string t;
      both = lvl_above && lvl_below;
      c  = (lvl_above && !lvl_below) ? 0 : ((lvl_below && !lvl_above) ? 1 : 2);
      nm = (c == 2) ? m_mid + 1 : 0;
      nv = (c != 2) ? m_val + 1 : 0;
      need = (m_cmd == 0) ? MHI : ((m_cmd == 1) ? MLO : 0);
      ok = (m_since + 1 >= need);
      nc = m_cmd;
      t  = "R1";
      if (m_cmd == 2) begin
        t = "R6";
        if (c != 2 && nv >= EXT) nc = c;
      end else if ((c == 2 && nm >= HOLD) || (c != 2 && c != m_cmd)) begin
        if (!ok) t = (c == 2) ? "R9" : ((m_cmd == 0) ? "R4" : "R5");
        else begin nc = c; t = (c == 2) ? "R3" : "R1"; end
      end else if (c == 2) t = "R3";
      if (both && t == "R3") t = "R2";
      m_since <= (nc != m_cmd) ? 0 : m_since + 1;
      m_cmd <= nc; m_mid <= nm; m_val <= nv; m_tag <= t;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cmd_code(logic h, logic l);
    return h ? 0 : (l ? 1 : 2);
  endfunction

  always @(negedge clk) begin
    if (running && rst_n) begin
      check(cmd_code(drv_hi, drv_lo) == m_cmd, m_tag, cmd_code(drv_hi, drv_lo), m_cmd);
      check(!(drv_hi && drv_lo), "R7", {30'd0, drv_hi, drv_lo}, 0);
    end
  end

  // level code: 0 high, 1 low, 2 open mid, 3 both flags (mid)
  task automatic put(int code, int n);
    for (int i = 0; i < n; i++) begin
      lvl_above = (code == 0) || (code == 3);
      lvl_below = (code == 1) || (code == 3);
      @(posedge clk); #1;
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #5;
    @(negedge clk);
    check(!drv_hi && !drv_lo, "R8", cmd_code(drv_hi, drv_lo), 2);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;

    for (int f = 0; f < 2; f++)
      for (int len = 0; len < 8; len++)
        for (int t = 0; t < 3; t++) begin
          put(f, 8);
          put((len % 2) ? 3 : 2, len);
          put(t, 8);
        end

    for (int t = 0; t < 2; t++)
      for (int v = 0; v < 4; v++) begin
        put(2, HOLD + 3);
        put(t, v);
        put(3, 1);
        put(t, 6);
      end

    put(1, 8); put(0, 1); put(2, 7);
    put(0, 8); put(1, 1); put(3, 7);
    put(1, 8); put(0, 2); put(1, 6);

    for (int r = 0; r < 400; r++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      put(int'(lfsr[1:0]), 1 + int'(lfsr[6:4]));
    end

    put(0, 8);
    @(negedge clk);
    rst_n = 1'b0;
    running = 1'b0;
    #1;
    check(!drv_hi && !drv_lo, "R8", cmd_code(drv_hi, drv_lo), 2);
    @(negedge clk);
    check(!drv_hi && !drv_lo, "R8", cmd_code(drv_hi, drv_lo), 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule